// File: doc/BRIEF.md
# Prescaled Compare-Clear Timer

An 8-bit timer/counter with a register interface for a processor. A power-of-two prescaler sets how often the counter advances. A 4-bit clock-select code picks the ratio, and code 0 stops the counter. A third compare register can set the top of the count. With clear-on-compare enabled, the counter returns to zero on the prescaled tick after it reaches that top value, so it has a period of top plus one ticks.

The block sets three sticky flags: overflow, match A and match B. Writing a 1 to a flag bit clears that flag. A per-flag acknowledge input also clears it. A flag raises its interrupt request line when the matching mask bit is set and the global interrupt enable input is high. The request stays high until the flag is cleared. Writes go through a single write port. Reads are combinational through a separate read address.

Top module: `pre_timer`

## Requirements
- R1: Register addresses are: control 0, counter 1, compare A 2, compare B 3, compare C (top) 4, flags 5, mask 6. In the control register, bits 3:0 hold the clock-select code and bit 7 enables clear-on-compare. Flag and mask bit 0 is overflow, bit 1 is match A and bit 2 is match B. Unused bits read 0.
- R2: With clock-select code 0, the counter never changes except through a write to the counter register.
- R3: Code n from 1 to 15 advances the counter once every 2^(n-1) clocks. The prescaler phase restarts on a counter write and while the code is 0. For example, code 8 gives the first advance 128 clocks after a counter write.
- R4: With clear-on-compare enabled, a tick that finds the counter equal to compare C loads 0 instead of incrementing. For example, with top 9 and a start of 8, three ticks give 9, 0, 1.
- R5: The overflow flag is set on every wrap to 0. A wrap happens from compare C in clear-on-compare mode, and from 255 in either mode. With top 249 and code 8, the flag is set exactly 32000 clocks after the counter is loaded with 0.
- R6: A tick that makes the counter equal to compare A sets match A, and a tick that makes it equal to compare B sets match B.
- R7: A counter write loads the value directly and sets no flag, even when the value equals a compare register.
- R8: Writing the flags register clears each flag whose data bit is 1 and leaves the flags whose data bit is 0 unchanged.
- R9: irq_o[i] is high exactly while flag i, mask bit i and gie_i are all high.
- R10: irq_ack_i[i] clears flag i. If an event sets the flag in the same cycle, the set wins.
- R11: After reset, all registers read 0 and irq_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| we_i | input | 1 | Register write strobe |
| waddr_i | input | 3 | Write address |
| wdata_i | input | 8 | Write data |
| raddr_i | input | 3 | Read address |
| rdata_o | output | 8 | Read data (combinational) |
| gie_i | input | 1 | Global interrupt enable |
| irq_ack_i | input | 3 | Per-flag interrupt acknowledge |
| irq_o | output | 3 | Per-flag interrupt request |

## Verification
The bench uses the default parameters: an 8-bit counter and a 4-bit clock select, which allows prescale ratios up to 2^14. The random phase keeps clock-select codes between 0 and 3 and compare values small, so wraps, matches and acknowledge collisions occur every few dozen clocks. Directed runs cover the code-8 ratio and the full 32000-clock period with top 249. A plain wrap at 255 is also checked with clear-on-compare disabled.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  typedef enum logic [2:0] {
    A_CTRL = 3'd0,
    A_CNT  = 3'd1,
    A_CMPA = 3'd2,
    A_CMPB = 3'd3,
    A_CMPC = 3'd4,
    A_FLAG = 3'd5,
    A_MASK = 3'd6
  } reg_addr_e;

  localparam int NFLAG    = 3;
  localparam int FL_OVF   = 0;
  localparam int FL_CMA   = 1;
  localparam int FL_CMB   = 2;
  localparam int CTRL_CLR = 7;
endpackage

// File: rtl/tmr_prescale.sv
module tmr_prescale #(
  parameter int CSEL_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CSEL_W-1:0] csel_i,
  input  logic              restart_i,
  output logic              tick_o
);
  localparam int PS_W = (1 << CSEL_W) - 1;

  logic [PS_W-1:0] ps_q, mask;

  always_comb begin
    mask = '0;
    if (csel_i != '0) mask = (PS_W'(1) << (csel_i - CSEL_W'(1))) - PS_W'(1);
  end

  assign tick_o = (csel_i != '0) && ((ps_q & mask) == mask);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ps_q <= '0;
    else if (restart_i || csel_i == '0) ps_q <= '0;
    else ps_q <= ps_q + PS_W'(1);
  end

  AST_STOP_NO_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (csel_i == '0) |-> !tick_o); // R2
endmodule

// File: rtl/tmr_count.sv
module tmr_count #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         tick_i,
  input  logic         clr_mode_i,
  input  logic [W-1:0] top_i,
  input  logic [W-1:0] cmp_a_i,
  input  logic [W-1:0] cmp_b_i,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  output logic [W-1:0] cnt_o,
  output logic         wrap_o,
  output logic         hit_a_o,
  output logic         hit_b_o
);
  logic [W-1:0] cnt_q, nxt;
  logic         step;

  assign step    = tick_i && !load_i;
  assign wrap_o  = step && ((clr_mode_i && cnt_q == top_i) || (&cnt_q));
  assign nxt     = wrap_o ? '0 : cnt_q + W'(1);
  assign hit_a_o = step && (nxt == cmp_a_i);
  assign hit_b_o = step && (nxt == cmp_b_i);
  assign cnt_o   = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else if (load_i) cnt_q <= load_val_i;
    else if (tick_i) cnt_q <= nxt;
  end

  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !load_i) |=> $stable(cnt_q)); // R2
  AST_CLR_AT_TOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !load_i && clr_mode_i && cnt_q == top_i) |=> (cnt_q == '0)); // R4
  AST_LOAD_DIRECT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (cnt_q == $past(load_val_i))); // R7
  AST_LOAD_NO_EVT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |-> !(wrap_o || hit_a_o || hit_b_o)); // R7
endmodule

// File: rtl/tmr_flags.sv
module tmr_flags #(
  parameter int N = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  input  logic [N-1:0] ack_i,
  input  logic [N-1:0] mask_i,
  input  logic         gie_i,
  output logic [N-1:0] flags_o,
  output logic [N-1:0] irq_o
);
  logic [N-1:0] flag_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flag_q <= '0;
    else flag_q <= (flag_q & ~clr_i & ~ack_i) | set_i;
  end

  assign flags_o = flag_q;
  assign irq_o   = flag_q & mask_i & {N{gie_i}};

  for (genvar i = 0; i < N; i++) begin : g_chk
    AST_SET_STICKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      set_i[i] |=> flag_q[i]); // R6
    AST_W1C: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (clr_i[i] && !set_i[i]) |=> !flag_q[i]); // R8
    AST_ACK_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ack_i[i] && !set_i[i]) |=> !flag_q[i]); // R10
    AST_FLAG_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!set_i[i] && !clr_i[i] && !ack_i[i]) |=> $stable(flag_q[i])); // R8
  end
endmodule

// File: rtl/pre_timer.sv
module pre_timer #(
  parameter int CNT_W  = 8,
  parameter int CSEL_W = 4
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     we_i,
  input  logic [2:0]               waddr_i,
  input  logic [CNT_W-1:0]         wdata_i,
  input  logic [2:0]               raddr_i,
  output logic [CNT_W-1:0]         rdata_o,
  input  logic                     gie_i,
  input  logic [tmr_pkg::NFLAG-1:0] irq_ack_i,
  output logic [tmr_pkg::NFLAG-1:0] irq_o
);
  import tmr_pkg::*;

  logic [CSEL_W-1:0] csel_q;
  logic              clr_mode_q;
  logic [CNT_W-1:0]  cmp_a_q, cmp_b_q, cmp_c_q, cnt;
  logic [NFLAG-1:0]  mask_q, flags, set_ev, w1c;
  logic              tick, load, wrap, hit_a, hit_b;
  logic [CNT_W-1:0]  ctrl_rd;

  assign load = we_i && (waddr_i == A_CNT);
  assign w1c  = (we_i && waddr_i == A_FLAG) ? wdata_i[NFLAG-1:0] : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      csel_q     <= '0;
      clr_mode_q <= 1'b0;
      cmp_a_q    <= '0;
      cmp_b_q    <= '0;
      cmp_c_q    <= '0;
      mask_q     <= '0;
    end else if (we_i) begin
      case (waddr_i)
        A_CTRL: begin
          csel_q     <= wdata_i[CSEL_W-1:0];
          clr_mode_q <= wdata_i[CTRL_CLR];
        end
        A_CMPA: cmp_a_q <= wdata_i;
        A_CMPB: cmp_b_q <= wdata_i;
        A_CMPC: cmp_c_q <= wdata_i;
        A_MASK: mask_q  <= wdata_i[NFLAG-1:0];
        default: ;
      endcase
    end
  end

  tmr_prescale #(.CSEL_W(CSEL_W)) u_ps (
    .clk_i, .rst_ni, .csel_i(csel_q), .restart_i(load), .tick_o(tick)
  );

  tmr_count #(.W(CNT_W)) u_cnt (
    .clk_i, .rst_ni, .tick_i(tick), .clr_mode_i(clr_mode_q), .top_i(cmp_c_q),
    .cmp_a_i(cmp_a_q), .cmp_b_i(cmp_b_q), .load_i(load), .load_val_i(wdata_i),
    .cnt_o(cnt), .wrap_o(wrap), .hit_a_o(hit_a), .hit_b_o(hit_b)
  );

  always_comb begin
    set_ev         = '0;
    set_ev[FL_OVF] = wrap;
    set_ev[FL_CMA] = hit_a;
    set_ev[FL_CMB] = hit_b;
  end

  tmr_flags #(.N(NFLAG)) u_flg (
    .clk_i, .rst_ni, .set_i(set_ev), .clr_i(w1c), .ack_i(irq_ack_i),
    .mask_i(mask_q), .gie_i, .flags_o(flags), .irq_o
  );

  always_comb begin
    ctrl_rd                 = '0;
    ctrl_rd[CSEL_W-1:0]     = csel_q;
    ctrl_rd[CTRL_CLR]       = clr_mode_q;
  end

  always_comb begin
    case (raddr_i)
      A_CTRL:  rdata_o = ctrl_rd;
      A_CNT:   rdata_o = cnt;
      A_CMPA:  rdata_o = cmp_a_q;
      A_CMPB:  rdata_o = cmp_b_q;
      A_CMPC:  rdata_o = cmp_c_q;
      A_FLAG:  rdata_o = CNT_W'(flags);
      A_MASK:  rdata_o = CNT_W'(mask_q);
      default: rdata_o = '0;
    endcase
  end

  AST_STOPPED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (csel_q == '0 && !load) |=> $stable(cnt)); // R2
  AST_IRQ_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !gie_i |-> (irq_o == '0)); // R9
  AST_OVF_ON_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick && !load && clr_mode_q && cnt == cmp_c_q) |=> flags[FL_OVF]); // R5
endmodule

// File: tb/pre_timer_test.sv
`timescale 1ns/1ps
module pre_timer_test;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       we_i = 1'b0;
  logic [2:0] waddr_i = '0;
  logic [7:0] wdata_i = '0;
  logic [2:0] raddr_i = '0;
  logic [7:0] rdata_o;
  logic       gie_i = 1'b0;
  logic [2:0] irq_ack_i = '0;
  logic [2:0] irq_o;

  int n_run = 0, n_fail = 0;
  bit done = 0;

  // bench model state
  int m_cnt, m_ps, m_csel, m_a, m_b, m_c, m_flag, m_mask;
  bit m_clr;

  pre_timer uut (.*);

  always #2.5 clk_i = ~clk_i;

  task automatic chk(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic rd(input int a, output int v);
    raddr_i = a[2:0];
    #0.1;
    v = int'(rdata_o);
  endtask

  task automatic model_reset();
    m_cnt = 0; m_ps = 0; m_csel = 0; m_a = 0; m_b = 0; m_c = 0;
    m_flag = 0; m_mask = 0; m_clr = 0;
  endtask

  task automatic model_step(input bit we, input int wa, input int wd, input int ack);
    int msk, nxt, ev, clrv;
    bit tick, load;
    msk  = (m_csel == 0) ? 0 : ((1 << (m_csel - 1)) - 1);
    tick = (m_csel != 0) && ((m_ps & msk) == msk);
    load = we && wa == 1;
    ev = 0;
    if (tick && !load) begin
      if ((m_clr && m_cnt == m_c) || m_cnt == 255) begin nxt = 0; ev |= 1; end
      else nxt = m_cnt + 1;
      if (nxt == m_a) ev |= 2;
      if (nxt == m_b) ev |= 4;
      m_cnt = nxt;
    end
    m_ps = (load || m_csel == 0) ? 0 : ((m_ps + 1) & 32'h7fff);
    clrv = (we && wa == 5) ? (wd & 7) : 0;
    m_flag = (m_flag & ~clrv & ~ack & 7) | ev;
    if (we) case (wa)
      0: begin m_csel = wd & 15; m_clr = wd[7]; end
      1: m_cnt = wd;
      2: m_a = wd;
      3: m_b = wd;
      4: m_c = wd;
      6: m_mask = wd & 7;
      default: ;
    endcase
  endtask

  task automatic check_model();
    int v;
    rd(0, v); chk("R1 ctrl", v, m_csel | (m_clr ? 128 : 0));
    rd(1, v); chk("R4 cnt", v, m_cnt);
    rd(2, v); chk("R1 cmpa", v, m_a);
    rd(3, v); chk("R1 cmpb", v, m_b);
    rd(4, v); chk("R1 cmpc", v, m_c);
    rd(5, v); chk("R5 flags", v, m_flag);
    rd(6, v); chk("R1 mask", v, m_mask);
    chk("R9 irq", int'(irq_o), m_flag & m_mask & (gie_i ? 7 : 0));
  endtask

  task automatic step(input bit we, input int wa, input int wd, input int ack);
    we_i = we; waddr_i = wa[2:0]; wdata_i = wd[7:0]; irq_ack_i = ack[2:0];
    @(posedge clk_i);
    model_step(we, wa, wd, ack);
    @(negedge clk_i);
    we_i = 0; irq_ack_i = 0;
    check_model();
  endtask

  task automatic wr(input int a, input int d);
    step(1, a, d, 0);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0);
  endtask

  function automatic int peek_cnt();
    return m_cnt;
  endfunction

  initial begin : watchdog
    #(200000 * 5);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual 0 expected 1 (run completed)");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin : main
    int v;
    int unsigned seed;
    seed = $urandom(32'd20240611);
    model_reset();
    #12;
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R11 reset state
    for (int a = 0; a < 7; a++) begin rd(a, v); chk("R11 reset reg", v, 0); end
    chk("R11 reset irq", int'(irq_o), 0);

    // R2: stopped
    wr(1, 37);
    idle(1000);
    rd(1, v); chk("R2 stopped", v, 37);

    // R3: code 1 and code 8
    wr(0, 1); wr(1, 0);
    idle(1); rd(1, v); chk("R3 code1", v, 1);
    wr(0, 8); wr(1, 0);
    idle(127); rd(1, v); chk("R3 code8 before", v, 0);
    idle(1);   rd(1, v); chk("R3 code8 at 128", v, 1);

    // R4 / R5: top 9 start 8
    wr(0, 0); wr(5, 7); wr(4, 9); wr(0, 8'h81); wr(1, 8);
    idle(1); rd(1, v); chk("R4 seq 9", v, 9);
    idle(1); rd(1, v); chk("R4 seq 0", v, 0);
    rd(5, v); chk("R5 ovf at wrap", v & 1, 1);
    idle(1); rd(1, v); chk("R4 seq 1", v, 1);

    // R8: write 0 keeps, write 1 clears
    wr(0, 0);
    wr(5, 0); rd(5, v); chk("R8 w0 keeps", v & 1, 1);
    wr(5, 1); rd(5, v); chk("R8 w1 clears", v & 1, 0);

    // R5: free run wrap at 255
    wr(0, 1); wr(1, 254);
    idle(1); rd(5, v); chk("R5 no ovf at 255", v & 1, 0);
    idle(1); rd(1, v); chk("R5 wrap cnt", v, 0);
    rd(5, v); chk("R5 ovf at 255 wrap", v & 1, 1);

    // R6: match A and B
    wr(0, 0); wr(5, 7); wr(2, 5); wr(3, 10); wr(4, 249);
    wr(0, 8'h81); wr(1, 4);
    idle(1); rd(5, v); chk("R6 match A", v & 2, 2);
    wr(1, 9);
    idle(1); rd(5, v); chk("R6 match B", v & 4, 4);

    // R7: load equal to compare sets nothing
    wr(0, 0); wr(5, 7); wr(1, 5); wr(1, 10);
    rd(5, v); chk("R7 load no flag", v, 0);

    // R9 / R10
    wr(6, 2); wr(0, 1); wr(1, 4);
    idle(1);
    chk("R9 gie low", int'(irq_o), 0);
    gie_i = 1; #0.1;
    chk("R9 irq A", int'(irq_o), 2);
    wr(0, 0);
    step(0, 0, 0, 2);
    chk("R10 ack clears", int'(irq_o), 0);
    rd(5, v); chk("R10 flag cleared", v & 2, 0);
    wr(2, 6); wr(0, 1); wr(1, 5);
    step(0, 0, 0, 2); // match A event collides with ack
    rd(5, v); chk("R10 set wins", v & 2, 2);
    wr(0, 0); wr(5, 7);

    // R5: full 32000-clock period
    wr(4, 249); wr(2, 0); wr(3, 0); wr(0, 8'h88); wr(1, 0);
    idle(31999); rd(5, v); chk("R5 period before", v & 1, 0);
    idle(1);     rd(5, v); chk("R5 period 32000", v & 1, 1);

    // constrained random
    for (int i = 0; i < 20000; i++) begin
      int a, d, ack;
      bit we;
      we = ($urandom % 8) == 0;
      a = $urandom % 7;
      d = $urandom % 256;
      if (a == 0) d = ($urandom % 4) | (($urandom % 2) << 7);
      if (a >= 2 && a <= 4) d = (($urandom % 8) == 0) ? 255 : ($urandom % 20);
      ack = (($urandom % 16) == 0) ? ($urandom % 8) : 0;
      if (($urandom % 64) == 0) gie_i = ~gie_i;
      step(we, a, d, ack);
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule